// File: doc/BRIEF.md
# Five-Channel Down-Counting Timer Bank with Interrupts

This block holds five independent down-counters behind a plain 32-bit register bus. Each counter has a count buffer that holds its start value, and a read-only observation address that returns the live count. Channels 0 to 3 also hold a compare buffer, which is kept for a waveform stage outside this block. One shared control word carries, for every channel, a run bit, a manual-load bit, an output-polarity bit and a reload-mode bit. One shared interrupt word carries per-channel enable bits and per-channel sticky status bits, and drives one interrupt line per channel.

Counting is paced by one tick strobe per channel, which comes from an external prescaler. While a channel runs, each tick lowers its count by one. A tick that arrives at a count of zero is an expiry. On expiry the channel either reloads from its count buffer and keeps going, or it clears its own run bit and rests at zero. The bus has no stall: a write takes effect at the clock edge where `bus_wr` is high, and read data is combinational on `bus_rdata` while `bus_rd` is high. No port carries streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_timer_bank`

## Requirements
- R1: The two configuration words (0x00, 0x04), the count buffers (channel c at 0x0C+12c for c=0..3, channel 4 at 0x3C) and the compare buffers (0x10+12c, c=0..3) read back the last value written to them.
- R2: A control-word write (0x08) that takes a channel's manual-load bit from 0 to 1 copies that channel's count buffer into its counter. A write that leaves the bit at 1 does not reload.
- R3: The counter of a channel whose run bit is 1 decreases by one on each tick of that channel. A counter whose run bit is 0 ignores ticks.
- R4: A tick at count zero on a running channel sets status bit 5+c of the interrupt word (0x44). If enable bit c was set, it also raises irq_o[c]. If enable bit c was clear, the status bit is set but the line stays low.
- R5: On expiry with the reload-mode bit at 1, the counter takes the count-buffer value and keeps running. With the bit at 0, the channel's run bit reads back 0 and the counter stays at zero.
- R6: A write to the interrupt word loads bits 4:0 (the enables) directly. Writing 1 to one of bits 9:5 clears that status bit, and writing 0 leaves it unchanged. Bits 31:10 read as 0.
- R7: irq_o[c] falls when status bit 5+c is cleared. If a clearing write and an expiry of the same channel fall in the same cycle, the status stays set and the line stays high.
- R8: The observation address (0x14+12c for c=0..3, 0x40 for channel 4) returns the live count of that channel.
- R9: Reads of unmapped offsets (for example 0x48) return 0. Writes to them change no register.
- R10: After reset the control word, the interrupt word, all buffers and all counters read 0, irq_o is 0, and no counter runs.
- R11: In the control word, channel 0 uses bits 0 (run), 1 (manual load), 2 (polarity) and 3 (reload mode). Channel c=1..3 uses bits 4+4c to 7+4c in the same order. Channel 4 uses bit 20 (run), bit 21 (manual load) and bit 22 (reload mode). The whole word reads back as written, except for run bits that the hardware has cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe, gates bus_rdata |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when bus_rd is low |
| tick_i | input | 5 | Per-channel count strobe from the prescaler |
| irq_o | output | 5 | Per-channel interrupt lines |

## Verification
The assertions check on every cycle that each counter holds still when it is neither loaded nor ticked, that it steps down by exactly one, and that it takes its buffer value on a manual load or an auto-reload. They also check that an expiry always leaves its status bit set, that an interrupt line is never high without its status bit, that a one-shot expiry drops the run bit, and that an unmapped write leaves the control word unchanged. The bus-level results can be shown only by the bench's scenarios. These are the read-back of every register class, the irregular control-bit layout of channel 4, the write-one-to-clear rule against writes of zero, the priority of an expiry over a clearing write in the same cycle, and the return to the reset state in the middle of a run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NUM_CH   = 5;
  localparam int CFG0_OFS = 'h00;
  localparam int CFG1_OFS = 'h04;
  localparam int CTRL_OFS = 'h08;
  localparam int IRQ_OFS  = 'h44;
  localparam int GRP_BASE = 'h0C;
  localparam int GRP_STEP = 12;

  // control word layout: channel 0 packed at the bottom, others at 4+4c
  function automatic int run_bit(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int load_bit(input int ch);
    return run_bit(ch) + 1;
  endfunction

  // last channel keeps its reload-mode bit one place lower (no polarity bit)
  function automatic int reload_bit(input int ch);
    return (ch == NUM_CH - 1) ? run_bit(ch) + 2 : run_bit(ch) + 3;
  endfunction

  function automatic int cntbuf_addr(input int ch);
    return GRP_BASE + GRP_STEP * ch;
  endfunction

  function automatic int cmpbuf_addr(input int ch);
    return cntbuf_addr(ch) + 4;
  endfunction

  // last channel has no compare buffer, so its observation slot moves up
  function automatic int obs_addr(input int ch);
    return (ch == NUM_CH - 1) ? cntbuf_addr(ch) + 4 : cntbuf_addr(ch) + 8;
  endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             auto_rl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  // a manual load in the same cycle takes precedence over the tick
  assign expire_o = run_i && tick_i && at_zero && !load_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload_i;
    end else if (run_i && tick_i) begin
      if (!at_zero) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end else if (auto_rl_i) begin
        cnt_q <= reload_i;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(run_i && tick_i)) |=> $stable(cnt_q)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && run_i && tick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(reload_i))); // R2
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && auto_rl_i) |=> (cnt_q == $past(reload_i))); // R5

endmodule

// File: rtl/tmr_irq_reg.sv
module tmr_irq_reg #(
  parameter int N_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [2*N_CH-1:0] wdata_i,
  input  logic [N_CH-1:0]   expire_i,
  output logic [2*N_CH-1:0] word_o,
  output logic [N_CH-1:0]   irq_o
);

  logic [N_CH-1:0] en_q, sts_q, irq_q;
  logic [N_CH-1:0] en_d, sts_d, irq_d;

  always_comb begin
    en_d  = wr_i ? wdata_i[N_CH-1:0] : en_q;
    // clear-by-one first, hardware set afterwards so the set wins
    sts_d = (wr_i ? (sts_q & ~wdata_i[2*N_CH-1:N_CH]) : sts_q) | expire_i;
    for (int i = 0; i < N_CH; i++) begin
      if (expire_i[i] && en_q[i]) begin
        irq_d[i] = 1'b1;
      end else if (sts_q[i] && !sts_d[i]) begin
        irq_d[i] = 1'b0;
      end else begin
        irq_d[i] = irq_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end

  assign word_o = {sts_q, en_q};
  assign irq_o  = irq_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    AST_STATUS_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      expire_i[i] |=> sts_q[i]); // R4
    AST_LINE_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i[i] && en_q[i]) |=> irq_q[i]); // R4
    AST_LINE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[i] |-> sts_q[i]); // R7
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] irq_o
);

  localparam int IRQ_W = 2 * NUM_CH;

  logic [DATA_W-1:0] cfg0_q, cfg1_q, ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cntbuf_v [NUM_CH];
  logic [CNT_W-1:0]  cmpbuf_v [NUM_CH];
  logic [CNT_W-1:0]  cnt_v    [NUM_CH];
  logic [NUM_CH-1:0] run, rl_mode, load, expire;
  logic [IRQ_W-1:0]  irq_word;
  logic [DATA_W-1:0] rd_val;
  logic              hit;
  logic              ctrl_we, irq_we;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
  assign irq_we  = bus_wr && (bus_addr == ADDR_W'(IRQ_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(CFG0_OFS)) cfg0_q <= bus_wdata;
      if (bus_addr == ADDR_W'(CFG1_OFS)) cfg1_q <= bus_wdata;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cntbuf_q;

    assign run[ch]     = ctrl_q[run_bit(ch)];
    assign rl_mode[ch] = ctrl_q[reload_bit(ch)];
    assign load[ch]    = ctrl_we && bus_wdata[load_bit(ch)] && !ctrl_q[load_bit(ch)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cntbuf_q <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(cntbuf_addr(ch))) cntbuf_q <= bus_wdata[CNT_W-1:0];
    end
    assign cntbuf_v[ch] = cntbuf_q;

    if (ch < NUM_CH - 1) begin : g_cmp
      logic [CNT_W-1:0] cmpbuf_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmpbuf_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(cmpbuf_addr(ch))) cmpbuf_q <= bus_wdata[CNT_W-1:0];
      end
      assign cmpbuf_v[ch] = cmpbuf_q;
    end else begin : g_nocmp
      assign cmpbuf_v[ch] = '0;
    end

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load[ch]),
      .reload_i  (cntbuf_q),
      .run_i     (run[ch]),
      .tick_i    (tick_i[ch]),
      .auto_rl_i (rl_mode[ch]),
      .cnt_o     (cnt_v[ch]),
      .expire_o  (expire[ch])
    );

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[ch] && !rl_mode[ch]) |=> !run[ch]); // R5
  end

  // control word: bus write first, then hardware clears one-shot run bits
  always_comb begin
    ctrl_d = ctrl_we ? bus_wdata : ctrl_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (expire[ch] && !rl_mode[ch]) ctrl_d[run_bit(ch)] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  tmr_irq_reg #(.N_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (irq_we),
    .wdata_i  (bus_wdata[IRQ_W-1:0]),
    .expire_i (expire),
    .word_o   (irq_word),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    hit    = 1'b0;
    if (bus_addr == ADDR_W'(CFG0_OFS)) begin rd_val = cfg0_q; hit = 1'b1; end
    if (bus_addr == ADDR_W'(CFG1_OFS)) begin rd_val = cfg1_q; hit = 1'b1; end
    if (bus_addr == ADDR_W'(CTRL_OFS)) begin rd_val = ctrl_q; hit = 1'b1; end
    if (bus_addr == ADDR_W'(IRQ_OFS))  begin rd_val = DATA_W'(irq_word); hit = 1'b1; end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (bus_addr == ADDR_W'(cntbuf_addr(ch))) begin
        rd_val = DATA_W'(cntbuf_v[ch]); hit = 1'b1;
      end
      if (ch < NUM_CH - 1 && bus_addr == ADDR_W'(cmpbuf_addr(ch))) begin
        rd_val = DATA_W'(cmpbuf_v[ch]); hit = 1'b1;
      end
      if (bus_addr == ADDR_W'(obs_addr(ch))) begin
        rd_val = DATA_W'(cnt_v[ch]); hit = 1'b1;
      end
    end
  end

  assign bus_rdata = bus_rd ? rd_val : '0;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit && expire == '0) |=> $stable(ctrl_q)); // R9

endmodule

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_I = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 56;
  localparam vec_t VECS [N_VEC] = '{
    '{OP_W, 8'h00, 32'h0101,   32'h0,      4'd0 },
    '{OP_R, 8'h00, 32'h0,      32'h0101,   4'd1 },  // R1 config word
    '{OP_W, 8'h04, 32'h1234,   32'h0,      4'd0 },
    '{OP_R, 8'h04, 32'h0,      32'h1234,   4'd1 },  // R1
    '{OP_W, 8'h0C, 32'h3,      32'h0,      4'd0 },
    '{OP_R, 8'h0C, 32'h0,      32'h3,      4'd1 },  // R1 count buffer
    '{OP_W, 8'h10, 32'hAB,     32'h0,      4'd0 },
    '{OP_R, 8'h10, 32'h0,      32'hAB,     4'd1 },  // R1 compare buffer
    '{OP_W, 8'h44, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h44, 32'h0,      32'h01,     4'd6 },  // R6 enable direct
    '{OP_W, 8'h08, 32'h02,     32'h0,      4'd0 },
    '{OP_R, 8'h14, 32'h0,      32'h3,      4'd2 },  // R2 manual load
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h14, 32'h0,      32'h3,      4'd3 },  // R3 stopped ignores tick
    '{OP_W, 8'h08, 32'h09,     32'h0,      4'd0 },
    '{OP_R, 8'h08, 32'h0,      32'h09,     4'd11},  // R11 layout readback
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h14, 32'h0,      32'h2,      4'd8 },  // R8 live count
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h14, 32'h0,      32'h0,      4'd3 },  // R3 counted down
    '{OP_I, 8'h00, 32'h0,      32'h00,     4'd4 },  // R4 no line before expiry
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h14, 32'h0,      32'h3,      4'd5 },  // R5 auto reload
    '{OP_R, 8'h44, 32'h0,      32'h21,     4'd4 },  // R4 status bit 5
    '{OP_I, 8'h00, 32'h0,      32'h01,     4'd4 },  // R4 line up
    '{OP_W, 8'h44, 32'h21,     32'h0,      4'd0 },
    '{OP_R, 8'h44, 32'h0,      32'h01,     4'd6 },  // R6 write one clears
    '{OP_I, 8'h00, 32'h0,      32'h00,     4'd7 },  // R7 line drops
    '{OP_W, 8'h08, 32'h01,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h01,     32'h0,      4'd0 },
    '{OP_R, 8'h08, 32'h0,      32'h00,     4'd5 },  // R5 one-shot run bit cleared
    '{OP_R, 8'h14, 32'h0,      32'h0,      4'd5 },  // R5 rests at zero
    '{OP_R, 8'h44, 32'h0,      32'h21,     4'd4 },  // R4
    '{OP_W, 8'h44, 32'h21,     32'h0,      4'd0 },
    '{OP_W, 8'h3C, 32'h1,      32'h0,      4'd0 },
    '{OP_W, 8'h08, 32'h200000, 32'h0,      4'd0 },
    '{OP_R, 8'h40, 32'h0,      32'h1,      4'd11},  // R11 channel 4 load at bit 21
    '{OP_W, 8'h08, 32'h500000, 32'h0,      4'd0 },
    '{OP_W, 8'h44, 32'h10,     32'h0,      4'd0 },
    '{OP_T, 8'h00, 32'h10,     32'h0,      4'd0 },
    '{OP_R, 8'h40, 32'h0,      32'h0,      4'd3 },  // R3 channel 4 runs
    '{OP_T, 8'h00, 32'h10,     32'h0,      4'd0 },
    '{OP_R, 8'h40, 32'h0,      32'h1,      4'd5 },  // R5 reload mode at bit 22
    '{OP_R, 8'h44, 32'h0,      32'h210,    4'd4 },  // R4 status bit 9
    '{OP_I, 8'h00, 32'h0,      32'h10,     4'd4 },  // R4
    '{OP_W, 8'h48, 32'hFFFFFFFF, 32'h0,    4'd0 },
    '{OP_R, 8'h48, 32'h0,      32'h0,      4'd9 },  // R9 unmapped read
    '{OP_R, 8'h08, 32'h0,      32'h500000, 4'd9 },  // R9 write ignored
    '{OP_R, 8'h0C, 32'h0,      32'h3,      4'd9 },  // R9
    '{OP_W, 8'h44, 32'h200,    32'h0,      4'd0 },
    '{OP_R, 8'h44, 32'h0,      32'h0,      4'd6 },  // R6
    '{OP_I, 8'h00, 32'h0,      32'h00,     4'd7 }   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_i = '0;
  logic [4:0]  irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tick_timer_bank i_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick(input logic [4:0] m);
    tick_i = m;
    @(posedge clk); @(negedge clk);
    tick_i = '0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d, input logic [4:0] m);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_i = m;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; tick_i = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic [4:0] exp);
    #1;
    chk(req, {27'd0, irq_o}, {27'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_chk("R10 ctrl", 8'h08, 32'h0);
    rd_chk("R10 irq word", 8'h44, 32'h0);
    rd_chk("R10 buffer", 8'h0C, 32'h0);
    rd_chk("R10 count", 8'h14, 32'h0);
    irq_chk("R10 lines", 5'h00);
    tick(5'h1F);
    rd_chk("R10 stopped after reset", 8'h40, 32'h0);
    rd_chk("R10 no expiry after reset", 8'h44, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      case (VECS[i].op)
        OP_W: wr(VECS[i].addr, VECS[i].data);
        OP_R: rd_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
        OP_T: tick(VECS[i].data[4:0]);
        default: irq_chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp[4:0]);
      endcase
    end

    // R7 priority: expiry beats a clearing write in the same cycle
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h500002);
    wr(8'h08, 32'h500009);
    wr(8'h44, 32'h01);
    tick(5'h01);
    rd_chk("R4 expiry from zero", 8'h44, 32'h21);
    wr_tick(8'h44, 32'h21, 5'h01);
    rd_chk("R7 set wins over clear", 8'h44, 32'h21);
    irq_chk("R7 line held on collision", 5'h01);
    wr(8'h44, 32'h21);
    irq_chk("R7 line drops on clear", 5'h00);
    // R4 disabled channel sets status but not line
    wr(8'h44, 32'h00);
    tick(5'h01);
    rd_chk("R4 status without enable", 8'h44, 32'h20);
    irq_chk("R4 line stays low when disabled", 5'h00);
    wr(8'h44, 32'h00);
    rd_chk("R6 zero leaves status", 8'h44, 32'h20);

    // R10 reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R10 ctrl after reset", 8'h08, 32'h0);
    rd_chk("R10 irq word after reset", 8'h44, 32'h0);
    rd_chk("R10 buffer after reset", 8'h3C, 32'h0);
    rd_chk("R10 count after reset", 8'h40, 32'h0);
    irq_chk("R10 lines after reset", 5'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule